// File: doc/BRIEF.md
# Loopback Modem Status Delta Register

This block holds the modem status byte of a classic serial port while the port is in internal loopback. The four modem control outputs are fed back as the four status inputs through a fixed crossing. On each clock with loopback on, the new input levels are compared with the levels held in the byte. Any mismatch sets a sticky change flag. The levels are then updated.

Software reads the byte through a one-cycle read strobe. The value shown during the strobe is the value returned. The byte is cleared on the following edge. A change detected in that same edge survives the clear, so no event is lost. A single flag output reports that at least one change flag is pending, which can feed an interrupt priority stage. With loopback off, the byte holds its state and only a read can clear it.

Top module: `msr_loop_status`

## Requirements
- R1: While reset is asserted and right after it is released, `status_o` is 0x00 and `delta_any_o` is 0.
- R2: With loopback on, the edge after a control change puts control bit 0 on status bit 5 and control bit 1 on status bit 4.
- R3: With loopback on, the edge after a control change puts control bit 2 on status bit 6 and control bit 3 on status bit 7.
- R4: With loopback on, status bit 0 is set when the level for bit 4 changes in either direction. Status bit 1 is set on a change of bit 5, and status bit 3 on a change of bit 7.
- R5: Status bit 2 is set only when bit 6 is 1 and its new level is 0. A rise of bit 6 does not set it.
- R6: Status bits 3:0 are sticky. They stay set when the levels return to earlier values, and only a read clears them.
- R7: During the read strobe, `status_o` shows the byte being returned. With loopback off, the byte is 0x00 after that edge.
- R8: A read with loopback on leaves the freshly mapped levels in bits 7:4. Bits 3:0 then hold only the changes detected in that same edge.
- R9: With loopback off and no read, the byte holds its value whatever the control input does.
- R10: `delta_any_o` is 1 exactly when any of status bits 3:0 is set.
- R11: Control bits 7:4 have no effect on the byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_i | input | 8 | Modem control byte |
| loop_en_i | input | 1 | Internal loopback enable |
| rd_strobe_i | input | 1 | One-cycle read of the status byte |
| status_o | output | 8 | Status byte: levels in 7:4, change flags in 3:0 |
| delta_any_o | output | 1 | At least one change flag is pending |

## Verification
The bench lets ring indicate rise and then fall. A design that flags any change on that line would set bit 2 too early. It drives the four lines in both directions, so a wrong crossing would show up as swapped level or flag bits. It performs a read in the same cycle as a control change: a design that lets the clear win would lose that change flag. It also toggles the control bits with loopback off and sets the unused upper control bits. A design that let the levels follow in either case would corrupt the held byte.

// File: rtl/msr_loop_pkg.sv
package msr_loop_pkg;

  localparam int unsigned CTRL_W    = 8;
  localparam int unsigned NUM_LINES = 4;
  localparam int unsigned STAT_W    = 2 * NUM_LINES;

  // How a line's level change turns into a sticky flag.
  typedef enum logic {
    EDGE_ANY  = 1'b0,
    EDGE_FALL = 1'b1
  } edge_kind_e;

  // Line order matches the flag order: 0 clear-to-send, 1 data-set-ready,
  // 2 ring, 3 carrier. Returns the control bit that feeds the line.
  function automatic int unsigned ctrl_src(int unsigned line);
    case (line)
      0:       ctrl_src = 1;
      1:       ctrl_src = 0;
      2:       ctrl_src = 2;
      default: ctrl_src = 3;
    endcase
  endfunction

  function automatic edge_kind_e line_edge(int unsigned line);
    line_edge = (line == 2) ? EDGE_FALL : EDGE_ANY;
  endfunction

endpackage

// File: rtl/msr_line_map.sv
module msr_line_map
  import msr_loop_pkg::*;
#(
  parameter int unsigned LINES = NUM_LINES,
  parameter int unsigned CW    = CTRL_W
) (
  input  logic [CW-1:0]    ctrl_i,
  output logic [LINES-1:0] lvl_o
);

  logic unused_ctrl;
  assign unused_ctrl = ^ctrl_i[CW-1:LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    assign lvl_o[g] = ctrl_i[ctrl_src(g)];
  end

endmodule

// File: rtl/msr_delta_detect.sv
module msr_delta_detect
  import msr_loop_pkg::*;
#(
  parameter int unsigned LINES = NUM_LINES
) (
  input  logic             en_i,
  input  logic [LINES-1:0] cur_lvl_i,
  input  logic [LINES-1:0] new_lvl_i,
  output logic [LINES-1:0] ev_o
);

  for (genvar g = 0; g < LINES; g++) begin : g_edge
    if (line_edge(g) == EDGE_FALL) begin : g_fall
      assign ev_o[g] = en_i & cur_lvl_i[g] & ~new_lvl_i[g];
    end else begin : g_any
      assign ev_o[g] = en_i & (cur_lvl_i[g] ^ new_lvl_i[g]);
    end
  end

endmodule

// File: rtl/msr_status_reg.sv
module msr_status_reg
  import msr_loop_pkg::*;
#(
  parameter int unsigned LINES = NUM_LINES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             clr_i,
  input  logic [LINES-1:0] new_lvl_i,
  input  logic [LINES-1:0] ev_i,
  output logic [LINES-1:0] lvl_q,
  output logic [LINES-1:0] flag_q
);

  logic [LINES-1:0] lvl_d;
  logic [LINES-1:0] flag_d;
  logic             upd_en;

  // Next state: a fresh event wins over the read clear.
  always_comb begin
    lvl_d  = clr_i ? '0 : lvl_q;
    if (load_i) begin
      lvl_d = new_lvl_i;
    end
    flag_d = (clr_i ? '0 : flag_q) | ev_i;
    upd_en = load_i | clr_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q  <= '0;
      flag_q <= '0;
    end else if (upd_en) begin
      lvl_q  <= lvl_d;
      flag_q <= flag_d;
    end
  end

endmodule

// File: rtl/msr_loop_status.sv
module msr_loop_status
  import msr_loop_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CTRL_W-1:0] ctrl_i,
  input  logic              loop_en_i,
  input  logic              rd_strobe_i,
  output logic [STAT_W-1:0] status_o,
  output logic              delta_any_o
);

  logic [NUM_LINES-1:0] mapped_lvl;
  logic [NUM_LINES-1:0] held_lvl;
  logic [NUM_LINES-1:0] flags;
  logic [NUM_LINES-1:0] events;

  msr_line_map #(.LINES(NUM_LINES), .CW(CTRL_W)) u_map (
    .ctrl_i (ctrl_i),
    .lvl_o  (mapped_lvl)
  );

  msr_delta_detect #(.LINES(NUM_LINES)) u_detect (
    .en_i      (loop_en_i),
    .cur_lvl_i (held_lvl),
    .new_lvl_i (mapped_lvl),
    .ev_o      (events)
  );

  msr_status_reg #(.LINES(NUM_LINES)) u_reg (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (loop_en_i),
    .clr_i     (rd_strobe_i),
    .new_lvl_i (mapped_lvl),
    .ev_i      (events),
    .lvl_q     (held_lvl),
    .flag_q    (flags)
  );

  assign status_o    = {held_lvl, flags};
  assign delta_any_o = |flags;

endmodule

// File: rtl/msr_loop_status_chk.sv
module msr_loop_status_chk
  import msr_loop_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [CTRL_W-1:0] ctrl_i,
  input logic              loop_en_i,
  input logic              rd_strobe_i,
  input logic [STAT_W-1:0] status_o,
  input logic              delta_any_o
);

  AST_DSR_CTS_MAP: assert property (@(posedge clk) disable iff (!rst_n)
    loop_en_i |=> (status_o[5] == $past(ctrl_i[0])) && (status_o[4] == $past(ctrl_i[1]))); // R2

  AST_RI_DCD_MAP: assert property (@(posedge clk) disable iff (!rst_n)
    loop_en_i |=> (status_o[6] == $past(ctrl_i[2])) && (status_o[7] == $past(ctrl_i[3]))); // R3

  AST_CTS_CHANGE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_en_i && (status_o[4] != ctrl_i[1])) |=> status_o[0]); // R4

  AST_NO_RING_RISE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_en_i && !status_o[6] && !status_o[2]) |=> !status_o[2]); // R5

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_strobe_i && (status_o[3:0] != 4'h0)) |=> ((status_o[3:0] & $past(status_o[3:0])) == $past(status_o[3:0]))); // R6

  AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe_i && !loop_en_i) |=> (status_o == '0)); // R7

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_strobe_i && !loop_en_i) |=> $stable(status_o)); // R9

  AST_ANY_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    delta_any_o == (status_o[3:0] != 4'h0)); // R10

endmodule

bind msr_loop_status msr_loop_status_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ctrl_i      (ctrl_i),
  .loop_en_i   (loop_en_i),
  .rd_strobe_i (rd_strobe_i),
  .status_o    (status_o),
  .delta_any_o (delta_any_o)
);

// File: tb/msr_loop_status_test.sv
module msr_loop_status_test;

  localparam time CLK_PERIOD = 10ns;

  logic       clk;
  logic       rst_n;
  logic [7:0] ctrl_i;
  logic       loop_en_i;
  logic       rd_strobe_i;
  logic [7:0] status_o;
  logic       delta_any_o;

  int checks;
  int errors;
  bit done;

  msr_loop_status uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctrl_i      (ctrl_i),
    .loop_en_i   (loop_en_i),
    .rd_strobe_i (rd_strobe_i),
    .status_o    (status_o),
    .delta_any_o (delta_any_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // One-cycle read; returns the value shown while the strobe is high.
  task automatic do_read(output logic [7:0] val);
    rd_strobe_i = 1'b1;
    #1;
    val = status_o;
    step();
    rd_strobe_i = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; ctrl_i = 8'h00; loop_en_i = 1'b0; rd_strobe_i = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 status in reset", status_o, 8'h00);
    rst_n = 1'b1;
    step();
    chk("R1 status after reset", status_o, 8'h00);
    chk("R1 any flag after reset", {7'b0, delta_any_o}, 8'h00);
  endtask

  task automatic t_low_lines();
    logic [7:0] rv;
    loop_en_i = 1'b1;
    ctrl_i = 8'h03;
    step();
    chk("R2 dsr/cts levels", {4'h0, status_o[7:4]}, 8'h03);
    chk("R4 cts/dsr change flags", {4'h0, status_o[3:0]}, 8'h03);
    chk("R10 any flag set", {7'b0, delta_any_o}, 8'h01);
    do_read(rv);
    chk("R7 read value", rv, 8'h33);
    chk("R8 loop read keeps levels", status_o, 8'h30);
    chk("R10 any flag clear", {7'b0, delta_any_o}, 8'h00);
  endtask

  task automatic t_high_lines();
    ctrl_i = 8'h0C;
    step();
    chk("R3 ri/dcd levels", {4'h0, status_o[7:4]}, 8'h0C);
    chk("R4 both-direction flags", {4'h0, status_o[3:0]}, 8'h0B);
    chk("R5 no flag on ring rise", {7'b0, status_o[2]}, 8'h00);
  endtask

  task automatic t_ring_fall_sticky();
    ctrl_i = 8'h08;
    step();
    chk("R5 ring trailing flag", status_o, 8'h8F);
    ctrl_i = 8'h0C;
    step();
    chk("R6 flags stay after revert", status_o, 8'hCF);
  endtask

  task automatic t_read_with_event();
    logic [7:0] rv;
    ctrl_i = 8'h0D;
    do_read(rv);
    chk("R7 read value before clear", rv, 8'hCF);
    chk("R8 same-edge change survives", status_o, 8'hE2);
    do_read(rv);
    chk("R8 second read", status_o, 8'hE0);
  endtask

  task automatic t_upper_ignored();
    ctrl_i = 8'hFD;
    step();
    step();
    chk("R11 upper control bits", status_o, 8'hE0);
  endtask

  task automatic t_loop_off();
    logic [7:0] rv;
    loop_en_i = 1'b0;
    ctrl_i = 8'h00;
    step();
    ctrl_i = 8'h0A;
    step();
    chk("R9 hold with loop off", status_o, 8'hE0);
    do_read(rv);
    chk("R7 read value loop off", rv, 8'hE0);
    chk("R7 clear with loop off", status_o, 8'h00);
    loop_en_i = 1'b1;
    ctrl_i = 8'h0F;
    step();
    chk("R4 re-enable from cleared", status_o, 8'hFB);
  endtask

  initial begin
    checks = 0;
    errors = 0;
    done = 1'b0;
    t_reset();
    t_low_lines();
    t_high_lines();
    t_ring_fall_sticky();
    t_read_with_event();
    t_upper_ignored();
    t_loop_off();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule